// File: doc/BRIEF.md
# Multi-Port CRC Mismatch Recovery Unit

This block sits between the four receive lanes and the four transmit lanes of a network interface. Every lane delivers two byte streams: the local copy of a frame and the mirrored copy of the same frame as received on the same-numbered lane of a peer interface. Each copy is captured into its own small frame buffer while a CRC-16 (polynomial 0x1021) is accumulated over it, one byte per clock.

A frame is a payload followed by a two-byte check trailer. Once both copies on a lane are complete, a single service controller inspects the lane. If the two copies agree and the local copy checks clean, the local frame is forwarded unchanged. Otherwise the controller enters a fault state, broadcasts a one-cycle error notification carrying a one-hot lane mask, and enters repair. In repair it replays a verified copy on the lane's transmit side, local copy first if that one is clean, otherwise the mirror. While replaying, it recomputes the CRC over the emitted bytes and confirms it before returning to normal service. A lane on which neither copy checks clean is dropped and counted. A cycle counter bounds the fault-to-confirmation time and raises a sticky flag if the bound is exceeded.

Top module: `mport_crc_recovery`

## Requirements
- R1: Per copy, the CRC register is preset to 0xFFFF at frame start and updated MSB-first with polynomial 0x1021 for every accepted byte, with no final inversion. A copy counts as verified when the register is 0x0000 after its last byte, which is the case when the trailer holds the payload CRC high byte first.
- R2: The copies on lane k are compared only with each other, and a frame from lane k is only ever emitted on transmit lane k; at most one transmit lane is active in any cycle.
- R3: When both copies on a lane are complete, their full-frame CRC values are equal and the local copy is verified, the local frame is emitted unchanged on consecutive cycles, with tx_last marking its final byte, and no error notification is raised.
- R4: In every other case the controller raises err_notify for exactly one cycle with err_mask equal to the one-hot bit of the lane, before any repair byte of that lane is emitted.
- R5: Repair replays the local copy if it is verified, otherwise the mirror copy if that one is verified.
- R6: The CRC recomputed over the replayed bytes must be 0x0000; fix_done then pulses in the cycle right after the replay's tx_last, and normal service resumes.
- R7: If neither copy is verified, no byte is emitted for that frame and unrec_count increases by one (saturating).
- R8: Lanes that become ready together are serviced in ascending lane order.
- R9: The number of cycles from entry into the fault state through the confirmation cycle is counted; if it exceeds TIMEOUT_CYC, timeout_err is set and stays set until reset.
- R10: While a completed copy waits for service, further bytes on that copy's stream are ignored.
- R11: After reset no transmit lane is active, err_notify and timeout_err are low and unrec_count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | NPORT | Local copy byte valid, one bit per lane |
| rx_data | input | 8*NPORT | Local copy bytes, lane k in bits 8k+7..8k |
| rx_last | input | NPORT | Local copy last byte of frame |
| mir_valid | input | NPORT | Mirror copy byte valid, one bit per lane |
| mir_data | input | 8*NPORT | Mirror copy bytes, lane k in bits 8k+7..8k |
| mir_last | input | NPORT | Mirror copy last byte of frame |
| tx_valid | output | NPORT | Transmit byte valid per lane |
| tx_data | output | 8*NPORT | Transmit bytes, lane k in bits 8k+7..8k |
| tx_last | output | NPORT | Transmit last byte of frame |
| err_notify | output | 1 | One-cycle error notification broadcast to all lanes |
| err_mask | output | NPORT | One-hot lane of the notification |
| fix_done | output | 1 | Repair confirmed by re-verification |
| unrec_count | output | CNT_W | Frames dropped with both copies invalid |
| timeout_err | output | 1 | Sticky flag: repair exceeded the cycle bound |

## Verification
Every lane is swept with four copy patterns: both clean, local corrupted, mirror corrupted and both corrupted. This tells forwarding apart from repair from the local copy, repair from the mirror and dropping, and confirms that nothing leaks onto other lanes. A run where all lanes complete together with one faulty lane exposes the service order, and a second local frame sent before the mirror arrives shows whether pending copies are protected. A second instance with a tiny cycle bound separates fault sequences, which must raise the timeout flag, from clean forwarding, which must not.

// File: rtl/rcv_pkg.sv
package rcv_pkg;

  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam logic [15:0] CRC_POLY = 16'h1021;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_NOTIFY,
    ST_REPAIR,
    ST_CHECK
  } rcv_state_e;

  // One byte into the CRC register, most significant bit first.
  function automatic logic [15:0] crc16_byte(input logic [15:0] c_in, input logic [7:0] d);
    logic [15:0] c;
    logic        fb;
    c = c_in;
    for (int b = 7; b >= 0; b--) begin
      fb = c[15] ^ d[b];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/rcv_frame_capture.sv
module rcv_frame_capture
  import rcv_pkg::*;
#(
  parameter int MAXLEN = 16,
  localparam int LW = $clog2(MAXLEN + 1),
  localparam int AW = $clog2(MAXLEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          release_i,
  input  logic [AW-1:0] rd_addr,
  output logic          full,
  output logic [LW-1:0] len,
  output logic [15:0]   crc,
  output logic [7:0]    rd_data
);

  logic [7:0] mem [MAXLEN];
  logic       accept;
  logic       store;

  assign accept  = in_valid && !full;
  assign store   = accept && (int'(len) < MAXLEN);
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (store) mem[len[AW-1:0]] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      len  <= '0;
      crc  <= CRC_SEED;
    end else if (release_i) begin
      full <= 1'b0;
      len  <= '0;
      crc  <= CRC_SEED;
    end else if (accept) begin
      if (store) begin
        len <= len + LW'(1);
        crc <= crc16_byte(crc, in_data);
      end
      if (in_last) full <= 1'b1;
    end
  end

  AST_HOLD_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !release_i) |=> ($stable(crc) && $stable(len) && full)); // R10

endmodule

// File: rtl/rcv_recovery_ctrl.sv
module rcv_recovery_ctrl
  import rcv_pkg::*;
#(
  parameter int NPORT       = 4,
  parameter int MAXLEN      = 16,
  parameter int TIMEOUT_CYC = 125,
  parameter int CNT_W       = 8,
  localparam int PW = $clog2(NPORT),
  localparam int LW = $clog2(MAXLEN + 1),
  localparam int AW = $clog2(MAXLEN),
  localparam int TW = $clog2(TIMEOUT_CYC + MAXLEN + 4)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORT-1:0]     ready,
  input  logic [16*NPORT-1:0]  loc_crc,
  input  logic [16*NPORT-1:0]  mir_crc,
  input  logic [LW*NPORT-1:0]  loc_len,
  input  logic [LW*NPORT-1:0]  mir_len,
  input  logic [8*NPORT-1:0]   loc_rd,
  input  logic [8*NPORT-1:0]   mir_rd,
  output logic [AW-1:0]        rd_addr,
  output logic [NPORT-1:0]     release_o,
  output logic [NPORT-1:0]     tx_valid,
  output logic [8*NPORT-1:0]   tx_data,
  output logic [NPORT-1:0]     tx_last,
  output logic                 err_notify,
  output logic [NPORT-1:0]     err_mask,
  output logic                 fix_done,
  output logic [CNT_W-1:0]     unrec_count,
  output logic                 timeout_err
);

  rcv_state_e        state;
  logic [PW-1:0]     sel;
  logic [PW-1:0]     pick;
  logic              any_ready;
  logic [LW-1:0]     idx;
  logic              src_mir;
  logic [15:0]       rcrc;
  logic [TW-1:0]     tcnt;

  // Named internal events, used by the FSM and by the assertions.
  logic [15:0]       pk_loc_crc, pk_mir_crc;
  logic              pk_fault;
  logic [15:0]       cur_loc_crc, cur_mir_crc;
  logic [LW-1:0]     cur_loc_len, cur_mir_len, src_len;
  logic [7:0]        cur_loc_byte, cur_mir_byte, rep_byte, out_byte;
  logic              send_last, rep_last, drop_now, in_fault, in_repair;
  logic [NPORT-1:0]  sel_hot;

  // Lowest-numbered ready lane wins.
  always_comb begin
    pick      = '0;
    any_ready = 1'b0;
    for (int k = NPORT - 1; k >= 0; k--) begin
      if (ready[k]) begin
        pick      = PW'(k);
        any_ready = 1'b1;
      end
    end
  end

  always_comb begin
    sel_hot      = '0;
    sel_hot[sel] = 1'b1;
  end

  assign pk_loc_crc   = loc_crc[pick*16 +: 16];
  assign pk_mir_crc   = mir_crc[pick*16 +: 16];
  assign pk_fault     = (pk_loc_crc != pk_mir_crc) || (pk_loc_crc != 16'h0000);

  assign cur_loc_crc  = loc_crc[sel*16 +: 16];
  assign cur_mir_crc  = mir_crc[sel*16 +: 16];
  assign cur_loc_len  = loc_len[sel*LW +: LW];
  assign cur_mir_len  = mir_len[sel*LW +: LW];
  assign cur_loc_byte = loc_rd[sel*8 +: 8];
  assign cur_mir_byte = mir_rd[sel*8 +: 8];

  assign src_len   = src_mir ? cur_mir_len : cur_loc_len;
  assign rep_byte  = src_mir ? cur_mir_byte : cur_loc_byte;
  assign out_byte  = (state == ST_SEND) ? cur_loc_byte : rep_byte;
  assign in_fault  = (state == ST_NOTIFY);
  assign in_repair = (state == ST_REPAIR) || (state == ST_CHECK);
  assign send_last = (state == ST_SEND) && (idx == cur_loc_len - LW'(1));
  assign rep_last  = (state == ST_REPAIR) && (idx == src_len - LW'(1));
  assign drop_now  = in_fault && (cur_loc_crc != 16'h0000) && (cur_mir_crc != 16'h0000);

  assign rd_addr    = idx[AW-1:0];
  assign err_notify = in_fault;
  assign err_mask   = in_fault ? sel_hot : '0;
  assign fix_done   = (state == ST_CHECK) && (rcrc == 16'h0000);
  assign release_o  = (send_last || drop_now || state == ST_CHECK) ? sel_hot : '0;

  always_comb begin
    tx_valid = '0;
    tx_last  = '0;
    tx_data  = '0;
    if (state == ST_SEND || state == ST_REPAIR) begin
      tx_valid             = sel_hot;
      tx_last              = (send_last || rep_last) ? sel_hot : '0;
      tx_data[sel*8 +: 8]  = out_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      sel         <= '0;
      idx         <= '0;
      src_mir     <= 1'b0;
      rcrc        <= CRC_SEED;
      tcnt        <= '0;
      unrec_count <= '0;
      timeout_err <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (any_ready) begin
            sel   <= pick;
            idx   <= '0;
            tcnt  <= '0;
            rcrc  <= CRC_SEED;
            state <= pk_fault ? ST_NOTIFY : ST_SEND;
          end
        end
        ST_SEND: begin
          if (send_last) state <= ST_IDLE;
          else           idx   <= idx + LW'(1);
        end
        ST_NOTIFY: begin
          tcnt <= tcnt + TW'(1);
          if (drop_now) begin
            if (unrec_count != '1) unrec_count <= unrec_count + CNT_W'(1);
            state <= ST_IDLE;
          end else begin
            src_mir <= (cur_loc_crc != 16'h0000);
            state   <= ST_REPAIR;
          end
        end
        ST_REPAIR: begin
          tcnt <= tcnt + TW'(1);
          rcrc <= crc16_byte(rcrc, rep_byte);
          if (rep_last) state <= ST_CHECK;
          else          idx   <= idx + LW'(1);
        end
        ST_CHECK: begin
          if (rcrc != 16'h0000 && unrec_count != '1) unrec_count <= unrec_count + CNT_W'(1);
          if (int'(tcnt) + 1 > TIMEOUT_CYC) timeout_err <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_TX_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_valid)); // R2

  AST_NOTIFY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    err_notify |-> ($onehot(err_mask) && tx_valid == '0)); // R4

  AST_NOTIFY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_notify |=> !err_notify); // R4

  AST_REPAIR_AFTER_NOTIFY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REPAIR && $past(state) != ST_REPAIR) |-> $past(err_notify)); // R4

  AST_SEND_ONLY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEND) |-> (cur_loc_crc == cur_mir_crc && cur_loc_crc == 16'h0000)); // R3

  AST_CHECK_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CHECK) |-> ($past(tx_last) != '0)); // R6

  AST_DROP_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_now && unrec_count != '1) |=> (unrec_count == $past(unrec_count) + CNT_W'(1))); // R7

  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err); // R9

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (tx_valid == '0 && !err_notify && unrec_count == '0 && !timeout_err)); // R11

endmodule

// File: rtl/mport_crc_recovery.sv
module mport_crc_recovery
  import rcv_pkg::*;
#(
  parameter int NPORT       = 4,
  parameter int MAXLEN      = 16,
  parameter int TIMEOUT_CYC = 125,
  parameter int CNT_W       = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORT-1:0]    rx_valid,
  input  logic [8*NPORT-1:0]  rx_data,
  input  logic [NPORT-1:0]    rx_last,
  input  logic [NPORT-1:0]    mir_valid,
  input  logic [8*NPORT-1:0]  mir_data,
  input  logic [NPORT-1:0]    mir_last,
  output logic [NPORT-1:0]    tx_valid,
  output logic [8*NPORT-1:0]  tx_data,
  output logic [NPORT-1:0]    tx_last,
  output logic                err_notify,
  output logic [NPORT-1:0]    err_mask,
  output logic                fix_done,
  output logic [CNT_W-1:0]    unrec_count,
  output logic                timeout_err
);

  localparam int LW = $clog2(MAXLEN + 1);
  localparam int AW = $clog2(MAXLEN);

  logic [NPORT-1:0]    loc_full, mir_full, lane_release;
  logic [16*NPORT-1:0] loc_crc, mir_crc;
  logic [LW*NPORT-1:0] loc_len, mir_len;
  logic [8*NPORT-1:0]  loc_rd, mir_rd;
  logic [AW-1:0]       rd_addr;

  for (genvar k = 0; k < NPORT; k++) begin : g_lane
    rcv_frame_capture #(.MAXLEN(MAXLEN)) u_loc (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (rx_valid[k]),
      .in_data   (rx_data[k*8 +: 8]),
      .in_last   (rx_last[k]),
      .release_i (lane_release[k]),
      .rd_addr   (rd_addr),
      .full      (loc_full[k]),
      .len       (loc_len[k*LW +: LW]),
      .crc       (loc_crc[k*16 +: 16]),
      .rd_data   (loc_rd[k*8 +: 8])
    );
    rcv_frame_capture #(.MAXLEN(MAXLEN)) u_mir (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (mir_valid[k]),
      .in_data   (mir_data[k*8 +: 8]),
      .in_last   (mir_last[k]),
      .release_i (lane_release[k]),
      .rd_addr   (rd_addr),
      .full      (mir_full[k]),
      .len       (mir_len[k*LW +: LW]),
      .crc       (mir_crc[k*16 +: 16]),
      .rd_data   (mir_rd[k*8 +: 8])
    );
  end

  rcv_recovery_ctrl #(
    .NPORT       (NPORT),
    .MAXLEN      (MAXLEN),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .CNT_W       (CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready       (loc_full & mir_full),
    .loc_crc     (loc_crc),
    .mir_crc     (mir_crc),
    .loc_len     (loc_len),
    .mir_len     (mir_len),
    .loc_rd      (loc_rd),
    .mir_rd      (mir_rd),
    .rd_addr     (rd_addr),
    .release_o   (lane_release),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .tx_last     (tx_last),
    .err_notify  (err_notify),
    .err_mask    (err_mask),
    .fix_done    (fix_done),
    .unrec_count (unrec_count),
    .timeout_err (timeout_err)
  );

endmodule

// File: tb/test_mport_crc_recovery.sv
module test_mport_crc_recovery;

  localparam int NP  = 4;
  localparam int ML  = 16;
  localparam int CW  = 8;
  localparam int PLEN = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       dv [2][NP];
  logic [7:0] dd [2][NP];
  logic       dl [2][NP];

  logic [NP-1:0]   rx_valid, rx_last, mir_valid, mir_last;
  logic [8*NP-1:0] rx_data, mir_data;

  always_comb begin
    for (int k = 0; k < NP; k++) begin
      rx_valid[k]       = dv[0][k];
      rx_last[k]        = dl[0][k];
      rx_data[k*8 +: 8] = dd[0][k];
      mir_valid[k]       = dv[1][k];
      mir_last[k]        = dl[1][k];
      mir_data[k*8 +: 8] = dd[1][k];
    end
  end

  logic [NP-1:0]   tx_valid, tx_last, err_mask;
  logic [8*NP-1:0] tx_data;
  logic            err_notify, fix_done, timeout_err;
  logic [CW-1:0]   unrec_count;

  logic [NP-1:0]   t_tx_valid, t_tx_last, t_err_mask;
  logic [8*NP-1:0] t_tx_data;
  logic            t_err_notify, t_fix_done, t_timeout_err;
  logic [CW-1:0]   t_unrec_count;

  mport_crc_recovery #(.NPORT(NP), .MAXLEN(ML), .TIMEOUT_CYC(125), .CNT_W(CW)) i_mport_crc_recovery (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .mir_valid(mir_valid), .mir_data(mir_data), .mir_last(mir_last),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .err_notify(err_notify), .err_mask(err_mask), .fix_done(fix_done),
    .unrec_count(unrec_count), .timeout_err(timeout_err)
  );

  mport_crc_recovery #(.NPORT(NP), .MAXLEN(ML), .TIMEOUT_CYC(4), .CNT_W(CW)) i_mport_crc_recovery_tmo (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .mir_valid(mir_valid), .mir_data(mir_data), .mir_last(mir_last),
    .tx_valid(t_tx_valid), .tx_data(t_tx_data), .tx_last(t_tx_last),
    .err_notify(t_err_notify), .err_mask(t_err_mask), .fix_done(t_fix_done),
    .unrec_count(t_unrec_count), .timeout_err(t_timeout_err)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Frame store: [lane][0 local / 1 mirror][byte]
  logic [7:0] fb [NP][2][ML];
  int         fl [NP][2];

  function automatic logic [15:0] ref_crc(input int p, input int m, input int n);
    logic [15:0] r;
    r = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      r = r ^ {fb[p][m][i], 8'h00};
      for (int b = 0; b < 8; b++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    end
    return r;
  endfunction

  task automatic build(input int p, input int m, input int seed);
    logic [15:0] c;
    for (int i = 0; i < PLEN; i++) fb[p][m][i] = 8'((seed * 37 + i * 11 + p * 5 + 3) & 255);
    c = ref_crc(p, m, PLEN);
    fb[p][m][PLEN]     = c[15:8];
    fb[p][m][PLEN + 1] = c[7:0];
    fl[p][m] = PLEN + 2;
  endtask

  task automatic drive(input int p, input int m);
    for (int i = 0; i < fl[p][m]; i++) begin
      @(negedge clk);
      dv[m][p] = 1'b1;
      dd[m][p] = fb[p][m][i];
      dl[m][p] = (i == fl[p][m] - 1);
    end
    @(negedge clk);
    dv[m][p] = 1'b0;
    dl[m][p] = 1'b0;
  endtask

  // Monitor, sampling one time unit after each rising edge.
  logic [7:0] oq [NP][$];
  int         order_q [$];
  int         notify_cnt = 0, fix_cnt = 0, fix_bad = 0, notify_pre = 0;
  logic [NP-1:0] last_mask = '0;
  bit         prev_last = 1'b0;

  always begin
    @(posedge clk);
    #1;
    if (rst_n) begin
      if (err_notify) begin
        int tot;
        tot = 0;
        for (int k = 0; k < NP; k++) tot += oq[k].size();
        notify_cnt++;
        last_mask  = err_mask;
        notify_pre = tot;
      end
      if (fix_done) begin
        fix_cnt++;
        if (!prev_last) fix_bad++;
      end
      for (int k = 0; k < NP; k++) begin
        if (tx_valid[k]) oq[k].push_back(tx_data[k*8 +: 8]);
        if (tx_last[k])  order_q.push_back(k);
      end
      prev_last = (tx_last != '0);
    end
  end

  task automatic clear_mon();
    for (int k = 0; k < NP; k++) oq[k].delete();
    order_q.delete();
  endtask

  // Output on lane p must equal copy m of lane p; other lanes silent.
  task automatic chk_out(input int p, input int m, input bit expect_none, input string req);
    bit ok;
    int exp_n;
    exp_n = expect_none ? 0 : fl[p][m];
    ok = (oq[p].size() == exp_n);
    if (ok) for (int i = 0; i < exp_n; i++) if (oq[p][i] != fb[p][m][i]) ok = 1'b0;
    for (int k = 0; k < NP; k++) if (k != p && oq[k].size() != 0) ok = 1'b0;
    chk(ok, req, $sformatf("lane %0d byte stream (size)", p), oq[p].size(), exp_n);
  endtask

  int exp_unrec = 0;

  task automatic run_case(input int p, input int scen);
    int n0, f0, u0;
    string tag;
    clear_mon();
    n0 = notify_cnt; f0 = fix_cnt; u0 = int'(unrec_count);
    build(p, 0, p * 4 + scen + 1);
    build(p, 1, p * 4 + scen + 1);
    if (scen == 1 || scen == 3) fb[p][0][2] = fb[p][0][2] ^ 8'h5A;
    if (scen == 2 || scen == 3) fb[p][1][4] = fb[p][1][4] ^ 8'h81;
    fork
      drive(p, 0);
      drive(p, 1);
    join
    repeat (30) @(negedge clk);
    tag = $sformatf("lane%0d scen%0d", p, scen);
    case (scen)
      0: begin
        chk_out(p, 0, 1'b0, "R1/R3 clean forward");
        chk(notify_cnt == n0, "R3", {tag, " no notify"}, notify_cnt - n0, 0);
      end
      1: begin
        chk_out(p, 1, 1'b0, "R5 restore from mirror");
        chk(notify_cnt == n0 + 1 && last_mask == NP'(1 << p) && notify_pre == 0,
            "R4", {tag, " notify mask"}, int'(last_mask), 1 << p);
        chk(fix_cnt == f0 + 1 && fix_bad == 0, "R6", {tag, " fix_done"}, fix_cnt - f0, 1);
      end
      2: begin
        chk_out(p, 0, 1'b0, "R5 restore from local");
        chk(notify_cnt == n0 + 1 && last_mask == NP'(1 << p) && notify_pre == 0,
            "R4", {tag, " notify mask"}, int'(last_mask), 1 << p);
        chk(fix_cnt == f0 + 1 && fix_bad == 0, "R6", {tag, " fix_done"}, fix_cnt - f0, 1);
      end
      default: begin
        exp_unrec++;
        chk_out(p, 0, 1'b1, "R7 drop");
        chk(notify_cnt == n0 + 1 && last_mask == NP'(1 << p), "R4", {tag, " notify mask"},
            int'(last_mask), 1 << p);
        chk(int'(unrec_count) == exp_unrec && fix_cnt == f0, "R7", {tag, " unrec_count"},
            int'(unrec_count), exp_unrec);
      end
    endcase
    if (u0 < 0) n_fail++;
  endtask

  initial begin
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < NP; k++) begin
        dv[m][k] = 1'b0; dd[m][k] = 8'h00; dl[m][k] = 1'b0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(tx_valid == '0 && !err_notify, "R11", "tx idle and no notify after reset", int'(tx_valid), 0);
    chk(unrec_count == '0 && !timeout_err, "R11", "counter and flag clear after reset", int'(unrec_count), 0);

    // Sweep of lanes and copy patterns (R1..R7, R2)
    for (int p = 0; p < NP; p++) begin
      for (int s = 0; s < 4; s++) begin
        run_case(p, s);
        if (p == 0 && s == 0)
          chk(!t_timeout_err, "R9", "small-bound instance quiet after clean forward", int'(t_timeout_err), 0);
        if (p == 0 && s == 1)
          chk(t_timeout_err, "R9", "small-bound instance flags long repair", int'(t_timeout_err), 1);
      end
    end
    chk(!timeout_err, "R9", "default bound never exceeded", int'(timeout_err), 0);

    // R8: all lanes ready together, lane 1 faulty
    clear_mon();
    for (int k = 0; k < NP; k++) begin
      build(k, 0, 40 + k);
      build(k, 1, 40 + k);
    end
    fb[1][0][1] = fb[1][0][1] ^ 8'h10;
    fork
      drive(0, 0); drive(1, 0); drive(2, 0); drive(3, 0);
      drive(0, 1); drive(1, 1); drive(2, 1); drive(3, 1);
    join
    repeat (60) @(negedge clk);
    chk(order_q.size() == 4 && order_q[0] == 0 && order_q[1] == 1 && order_q[2] == 2 && order_q[3] == 3,
        "R8", "ascending service order (first lane)", order_q.size() > 0 ? order_q[0] : -1, 0);
    begin
      bit ok;
      ok = (oq[1].size() == fl[1][1]);
      if (ok) for (int i = 0; i < fl[1][1]; i++) if (oq[1][i] != fb[1][1][i]) ok = 1'b0;
      chk(ok, "R8/R5", "faulty lane repaired inside batch", oq[1].size(), fl[1][1]);
    end

    // R10: second local frame while first is pending is ignored
    clear_mon();
    build(2, 0, 90);
    build(2, 1, 90);
    drive(2, 0);
    build(2, 0, 91);
    drive(2, 0);
    begin
      int n0;
      n0 = notify_cnt;
      drive(2, 1);
      repeat (30) @(negedge clk);
      chk_out(2, 1, 1'b0, "R10 pending copy kept");
      chk(notify_cnt == n0, "R10", "no notify from ignored frame", notify_cnt - n0, 0);
    end

    chk(fix_bad == 0, "R6", "fix_done always one cycle after tx_last", fix_bad, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule